// File: doc/BRIEF.md
# Match-Compare Interval Timer

This block holds one free-running up-counter and four compare channels. The counter advances by one on every system clock cycle in which the tick-enable input is high. It is never reloaded or stopped by a match, and it wraps to zero after reaching all ones. Each channel holds an absolute match value. A channel's sticky status bit sets on the tick in which the counter steps onto that value. A per-channel enable mask decides whether that status bit drives the shared level interrupt.

Software schedules an event by reading the counter, adding an interval with unsigned wraparound, and writing the sum into a match register. For fine delays and timestamps it reads the counter directly, and those reads have no side effects. A watchdog-enable bit is stored and read back, and nothing else is done with it. All registers sit on a small word-addressed bus with a combinational read path and single-cycle writes.

Top module: `mct_timer`

## Requirements
- R1: After reset, every register (match 0..3, counter, status, watchdog enable, interrupt enable) reads 0 and `irq` is low.
- R2: The counter increases by exactly one on each clock edge where `tick_en` is 1, holds otherwise, and wraps from all ones to 0. Reading it changes nothing, and a bus write to the counter offset (4) is ignored.
- R3: Word offsets are: match n at offset n (0..3), counter at 4, status at 5, watchdog enable at 6, interrupt enable at 7. Match registers read back the low CNT_W bits written. The watchdog enable keeps only bit 0 and the interrupt enable keeps bits 3:0. Every other bit reads 0.
- R4: Status bit n sets on the clock edge at which a tick moves the counter onto the value of match register n. The counter keeps counting through the match, and channels with equal match values set together.
- R5: A status bit stays set until software writes 1 to that bit position at offset 5. Writing 0 to a bit leaves it unchanged.
- R6: When a clearing write and a new match hit the same status bit in the same cycle, the bit ends up set.
- R7: `irq` is a level output equal to the OR over n of (status bit n AND interrupt-enable bit n). Clearing the enable masks the interrupt without touching the status.
- R8: A match value below the current count fires after the counter wraps, so scheduling with unsigned current-plus-interval arithmetic works across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle counter advance strobe |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Level interrupt, OR of enabled status bits |

## Verification
The assertions assume that `tick_en` and the bus controls are already synchronous to `clk` and hold known values after reset. They also assume that a falling interrupt can only come from a software write to the status or enable offset. The stimulus drives every input on the falling edge, so nothing changes near the sampling edge. It makes the counter advance only through `tick_en`, and it issues at most one bus operation per cycle. The set-wins case is the one place where a clearing write deliberately coincides with a tick that lands on the match value.

// File: rtl/mct_pkg.sv
`timescale 1ns/1ps
package mct_pkg;
    localparam int NUM_CH  = 4;
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 32;

    typedef enum logic [ADDR_W-1:0] {
        OFS_MATCH0 = 3'd0,
        OFS_MATCH1 = 3'd1,
        OFS_MATCH2 = 3'd2,
        OFS_MATCH3 = 3'd3,
        OFS_COUNT  = 3'd4,
        OFS_STATUS = 3'd5,
        OFS_WDOG   = 3'd6,
        OFS_IEN    = 3'd7
    } reg_ofs_e;
endpackage

// File: rtl/mct_counter.sv
`timescale 1ns/1ps
module mct_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);
    always_comb cnt_nxt = cnt_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (tick_en) cnt_q <= cnt_nxt;
    end

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(cnt_q));
endmodule

// File: rtl/mct_channel.sv
`timescale 1ns/1ps
module mct_channel #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic             match_we,
    input  logic [CNT_W-1:0] match_wd,
    input  logic             stat_clr,
    output logic [CNT_W-1:0] match_q,
    output logic             stat_q
);
    logic hit;

    always_comb hit = tick_en && (cnt_nxt == match_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        match_q <= '0;
        else if (match_we) match_q <= match_wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        stat_q <= 1'b0;
        else if (hit)      stat_q <= 1'b1;
        else if (stat_clr) stat_q <= 1'b0;
    end

    // R4 R6
    hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && cnt_nxt == match_q) |=> stat_q);

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !stat_clr) |=> stat_q);

    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !(tick_en && cnt_nxt == match_q)) |=> !stat_q);
endmodule

// File: rtl/mct_timer.sv
`timescale 1ns/1ps
module mct_timer
    import mct_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_nxt;
    logic [CNT_W-1:0]  match_q [NUM_CH];
    logic [NUM_CH-1:0] stat_q;
    logic [NUM_CH-1:0] ien_q;
    logic              wdog_q;
    logic              wr_go;
    reg_ofs_e          ofs;

    always_comb begin
        ofs   = reg_ofs_e'(bus_addr);
        wr_go = bus_sel && bus_wr;
    end

    mct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        mct_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_en  (tick_en),
            .cnt_nxt  (cnt_nxt),
            .match_we (wr_go && bus_addr == ADDR_W'(n)),
            .match_wd (bus_wdata[CNT_W-1:0]),
            .stat_clr (wr_go && ofs == OFS_STATUS && bus_wdata[n]),
            .match_q  (match_q[n]),
            .stat_q   (stat_q[n])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q  <= '0;
            wdog_q <= 1'b0;
        end else if (wr_go) begin
            if (ofs == OFS_IEN)  ien_q  <= bus_wdata[NUM_CH-1:0];
            if (ofs == OFS_WDOG) wdog_q <= bus_wdata[0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (ofs)
            OFS_MATCH0: bus_rdata[CNT_W-1:0]  = match_q[0];
            OFS_MATCH1: bus_rdata[CNT_W-1:0]  = match_q[1];
            OFS_MATCH2: bus_rdata[CNT_W-1:0]  = match_q[2];
            OFS_MATCH3: bus_rdata[CNT_W-1:0]  = match_q[3];
            OFS_COUNT:  bus_rdata[CNT_W-1:0]  = cnt_q;
            OFS_STATUS: bus_rdata[NUM_CH-1:0] = stat_q;
            OFS_WDOG:   bus_rdata[0]          = wdog_q;
            OFS_IEN:    bus_rdata[NUM_CH-1:0] = ien_q;
        endcase
    end

    always_comb irq = |(stat_q & ien_q);

    // R7
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_go && (ofs == OFS_STATUS || ofs == OFS_IEN)));

    // R3
    wdog_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_go && ofs == OFS_WDOG) |=> $stable(wdog_q));

    // R3
    ien_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_go && ofs == OFS_IEN) |=> $stable(ien_q));
endmodule

// File: tb/mct_timer_bench.sv
`timescale 1ns/1ps
module mct_timer_bench;
    localparam int CNT_W = 16;
    localparam int CMASK = (1 << CNT_W) - 1;

    typedef struct packed {
        logic        wr;
        logic [2:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd0, 32'hDEADBEEF, 32'h0},
        '{1'b1, 3'd1, 32'h1234CAFE, 32'h0},
        '{1'b1, 3'd2, 32'h00008001, 32'h0},
        '{1'b1, 3'd3, 32'hFFFF7777, 32'h0},
        '{1'b0, 3'd0, 32'h0,        32'h0000BEEF},
        '{1'b0, 3'd1, 32'h0,        32'h0000CAFE},
        '{1'b0, 3'd2, 32'h0,        32'h00008001},
        '{1'b0, 3'd3, 32'h0,        32'h00007777},
        '{1'b1, 3'd6, 32'hFFFFFFFE, 32'h0},
        '{1'b0, 3'd6, 32'h0,        32'h0},
        '{1'b1, 3'd6, 32'h00000003, 32'h0},
        '{1'b0, 3'd6, 32'h0,        32'h1},
        '{1'b1, 3'd7, 32'hFFFFFFF5, 32'h0},
        '{1'b0, 3'd7, 32'h0,        32'h5},
        '{1'b1, 3'd7, 32'h0,        32'h0},
        '{1'b0, 3'd7, 32'h0,        32'h0},
        '{1'b0, 3'd5, 32'h0,        32'h0},
        '{1'b0, 3'd4, 32'h0,        32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    int tb_cnt = 0;
    bit done = 0;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    mct_timer #(.CNT_W(CNT_W)) u_mct_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
        tb_cnt += n;
    endtask

    initial begin
        #900000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd_reg(3'(a), rd);
            chk("R1 reset read", rd, 32'h0);
        end
        chk("R1 reset irq", {31'b0, irq}, 32'h0);

        // R3 register map via vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) wr_reg(VEC[i].addr, VEC[i].data);
            else begin
                rd_reg(VEC[i].addr, rd);
                chk("R3 map readback", rd, VEC[i].exp);
            end
        end

        // R2 counting, read without side effect, write ignored
        ticks(10);
        rd_reg(3'd4, rd); chk("R2 count", rd, 32'(tb_cnt));
        rd_reg(3'd4, rd); chk("R2 reread", rd, 32'(tb_cnt));
        wr_reg(3'd4, 32'h1234);
        rd_reg(3'd4, rd); chk("R2 write ignored", rd, 32'(tb_cnt));

        // R4 R7 match and interrupt
        wr_reg(3'd7, 32'h2);
        wr_reg(3'd1, 32'(tb_cnt + 5));
        ticks(4);
        rd_reg(3'd5, rd); chk("R4 before match", rd, 32'h0);
        chk("R7 irq low", {31'b0, irq}, 32'h0);
        ticks(1);
        rd_reg(3'd5, rd); chk("R4 on match", rd, 32'h2);
        chk("R7 irq high", {31'b0, irq}, 32'h1);
        ticks(3);
        rd_reg(3'd4, rd); chk("R4 counter runs on", rd, 32'(tb_cnt));
        rd_reg(3'd5, rd); chk("R5 sticky", rd, 32'h2);
        wr_reg(3'd5, 32'h1);
        rd_reg(3'd5, rd); chk("R5 zero bit no effect", rd, 32'h2);
        wr_reg(3'd7, 32'h1);
        chk("R7 masked", {31'b0, irq}, 32'h0);
        rd_reg(3'd5, rd); chk("R7 mask keeps status", rd, 32'h2);
        wr_reg(3'd7, 32'h2);
        chk("R7 unmasked", {31'b0, irq}, 32'h1);
        wr_reg(3'd5, 32'h2);
        rd_reg(3'd5, rd); chk("R5 w1c", rd, 32'h0);
        chk("R7 irq after clear", {31'b0, irq}, 32'h0);

        // R6 set wins over clear
        wr_reg(3'd2, 32'(tb_cnt + 1));
        ticks(1);
        rd_reg(3'd5, rd); chk("R6 setup", rd, 32'h4);
        wr_reg(3'd2, 32'(tb_cnt + 1));
        @(negedge clk);
        tick_en = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 32'h4;
        @(negedge clk);
        tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        tb_cnt += 1;
        rd_reg(3'd5, rd); chk("R6 set wins", rd, 32'h4);
        wr_reg(3'd5, 32'h4);
        rd_reg(3'd5, rd); chk("R6 later clear", rd, 32'h0);

        // R4 two channels on one value
        wr_reg(3'd0, 32'(tb_cnt + 3));
        wr_reg(3'd3, 32'(tb_cnt + 3));
        wr_reg(3'd7, 32'hF);
        ticks(3);
        rd_reg(3'd5, rd); chk("R4 joint match", rd, 32'h9);
        chk("R7 any enabled", {31'b0, irq}, 32'h1);
        wr_reg(3'd5, 32'hF);

        // R8 wraparound scheduling
        wr_reg(3'd3, 32'h2);
        ticks(CMASK - (tb_cnt & CMASK));
        rd_reg(3'd4, rd); chk("R2 all ones", rd, 32'(CMASK));
        rd_reg(3'd5, rd); chk("R8 not before wrap", rd & 32'h8, 32'h0);
        ticks(1);
        rd_reg(3'd4, rd); chk("R2 wrap to zero", rd, 32'h0);
        ticks(2);
        rd_reg(3'd5, rd); chk("R8 fires after wrap", rd & 32'h8, 32'h8);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule